// File: doc/BRIEF.md
# Parity-Split Floating-Point Issue Selector

This block is the issue-select stage of a floating-point instruction queue. Instructions arrive in aligned groups of four lanes. Lanes 0 and 2 belong to the even half of the queue and lanes 1 and 3 belong to the odd half. Each half has eight slots by default, one pipelined multiply-accumulate unit and one non-pipelined divide/square-root unit. Every entry holds an operation class, a valid bit, a data-ready bit and an age tag. The age tag is a sequence number that grows as groups are accepted.

In every cycle, each half picks the oldest entry that is ready and whose unit is free, and issues it. An issued entry leaves the queue at that same clock edge, so two instructions can launch per cycle at most. A divide or square-root whose unit is still busy stays in its slot. Younger multiply-accumulate entries of the same half can issue past it. Readiness is given with each lane at enqueue, or it is set later by a wakeup that names an entry's age tag.

The group input is a valid/ready stream. A group is accepted at a rising edge where `grp_valid` and `grp_ready` are both high. `grp_ready` depends only on queue state, never on the current inputs. While it is low, the source must hold the group steady and wait. The issue outputs carry no back-pressure: each half's unit takes the grant in the cycle it is shown.

Top module: `fpis_issue_sel`

## Requirements
- R1: After reset, the queue is empty. `grp_ready` is 1 and both `iss_vld` bits are 0.
- R2: An accepted group gives its lane k the age tag (sequence + k) modulo 2^TAG_W. The sequence starts at 0 and advances by 4 on each accepted group, including lanes whose `grp_lane_vld` bit is 0; such lanes are not stored. Lanes 0 and 2 go to the even half (issue index 0) and lanes 1 and 3 go to the odd half (issue index 1).
- R3: `grp_ready` is 1 only while each half has at least two free slots. When `grp_valid` is high and `grp_ready` is low, nothing is stored and the sequence does not advance.
- R4: In each cycle, each half issues the oldest of its eligible entries on `iss_vld`/`iss_tag`/`iss_op`. An entry is eligible when it is valid and ready, and, for a divide/square-root, when that half's divide unit is free. `iss_op` is 0 for multiply-accumulate and 1 for divide/square-root (the `grp_op` bit uses the same code).
- R5: An entry becomes ready either from its `grp_rdy` bit at enqueue or when `wake_en` is high with `wake_tag` equal to its tag. In both cases it can issue from the next cycle on, and it is never issued while it is not ready.
- R6: After a half issues a divide/square-root, it issues no other divide/square-root for DIV_LAT-1 cycles. It may issue one again DIV_LAT cycles after the first. The two halves keep separate timers.
- R7: While a ready divide/square-root is blocked by its busy unit, a younger ready multiply-accumulate of the same half issues ahead of it.
- R8: An entry is removed at the edge that ends its issue cycle and is never issued twice.
- R9: Age comparison is wraparound safe: tag a is older than tag b when (a - b) mod 2^TAG_W has its top bit set. This ordering holds as long as live tags span less than 2^(TAG_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_valid | input | 1 | Group offered |
| grp_ready | output | 1 | Group can be accepted |
| grp_lane_vld | input | 4 | Per-lane instruction present |
| grp_op | input | 4 | Per-lane class, 1 = divide/square-root |
| grp_rdy | input | 4 | Per-lane data already ready |
| wake_en | input | 1 | Wakeup strobe |
| wake_tag | input | TAG_W | Age tag of the entry to mark ready |
| iss_vld | output | 2 | Issue grant, bit 0 even half, bit 1 odd half |
| iss_op | output | 2 | Class of each granted entry |
| iss_tag | output | 2*TAG_W | Tags of granted entries, even half in the low bits |

## Verification
The hardest case to reach is a ready divide/square-root that is older than a ready multiply-accumulate in the same half, while that half's divide timer is still running, and while the tag sequence is wrapping. The bench first issues one divide per half to start both timers. It then enqueues more divides together with multiply-accumulate work that is not yet ready, and wakes that work by tag during the busy window. Long sweeps on a reduced configuration drive the tags through several wraps. In those sweeps the bench keeps the live tag span legal by withholding groups, and it wakes the oldest waiting entry half the time.

// File: rtl/fpis_pkg.sv
package fpis_pkg;
  localparam int unsigned LANES    = 4;
  localparam int unsigned PARITIES = 2;

  typedef enum logic {
    OP_FMAC  = 1'b0,
    OP_DIVSQ = 1'b1
  } op_cls_e;
endpackage

// File: rtl/fpis_bank.sv
module fpis_bank
  import fpis_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_en,
  input  logic [1:0]             alloc_vld,
  input  logic [1:0]             alloc_op,
  input  logic [1:0]             alloc_rdy,
  input  logic [2*TAG_W-1:0]     alloc_tag,
  input  logic                   wake_en,
  input  logic [TAG_W-1:0]       wake_tag,
  input  logic [DEPTH-1:0]       take,
  output logic [DEPTH-1:0]       slot_vld,
  output logic [DEPTH-1:0]       slot_rdy,
  output logic [DEPTH-1:0]       slot_op,
  output logic [DEPTH*TAG_W-1:0] slot_tag,
  output logic                   room
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [IDX_W-1:0] free0, free1, tgt0, tgt1;
  logic             have0, have1;
  logic [CNT_W-1:0] nfree;

  // first two free slots
  always_comb begin
    free0 = '0;
    free1 = '0;
    have0 = 1'b0;
    have1 = 1'b0;
    nfree = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!slot_vld[i]) begin
        nfree = nfree + 1'b1;
        if (!have0) begin
          free0 = IDX_W'(i);
          have0 = 1'b1;
        end else if (!have1) begin
          free1 = IDX_W'(i);
          have1 = 1'b1;
        end
      end
    end
  end

  assign room = (nfree >= CNT_W'(2));
  assign tgt0 = free0;
  assign tgt1 = alloc_vld[0] ? free1 : free0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld <= '0;
      slot_rdy <= '0;
      slot_op  <= '0;
      slot_tag <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (take[i]) slot_vld[i] <= 1'b0;
        if (wake_en && slot_vld[i] && (slot_tag[i*TAG_W +: TAG_W] == wake_tag))
          slot_rdy[i] <= 1'b1;
      end
      if (alloc_en && alloc_vld[0]) begin
        slot_vld[tgt0]                   <= 1'b1;
        slot_rdy[tgt0]                   <= alloc_rdy[0];
        slot_op[tgt0]                    <= alloc_op[0];
        slot_tag[tgt0*TAG_W +: TAG_W]    <= alloc_tag[0 +: TAG_W];
      end
      if (alloc_en && alloc_vld[1]) begin
        slot_vld[tgt1]                   <= 1'b1;
        slot_rdy[tgt1]                   <= alloc_rdy[1];
        slot_op[tgt1]                    <= alloc_op[1];
        slot_tag[tgt1*TAG_W +: TAG_W]    <= alloc_tag[TAG_W +: TAG_W];
      end
    end
  end

  // R3: allocation only with room for two
  p_alloc_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> room);

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    // R5: a granted slot holds a ready entry
    p_take_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take[g] |-> (slot_vld[g] && slot_rdy[g]));
    // R8: a granted slot is empty afterwards
    p_removed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      take[g] |=> !slot_vld[g]);
  end
endmodule

// File: rtl/fpis_pick.sv
module fpis_pick
  import fpis_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DEPTH-1:0]       slot_vld,
  input  logic [DEPTH-1:0]       slot_rdy,
  input  logic [DEPTH-1:0]       slot_op,
  input  logic [DEPTH*TAG_W-1:0] slot_tag,
  input  logic                   div_free,
  output logic [DEPTH-1:0]       grant,
  output logic                   g_vld,
  output logic                   g_op,
  output logic [TAG_W-1:0]       g_tag
);
  logic [DEPTH-1:0] elig;

  function automatic logic is_older(input logic [TAG_W-1:0] a,
                                    input logic [TAG_W-1:0] b);
    logic [TAG_W-1:0] d;
    d = a - b;
    return d[TAG_W-1];
  endfunction

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      elig[i] = slot_vld[i] && slot_rdy[i] &&
                ((slot_op[i] == OP_FMAC) || div_free);
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      grant[i] = elig[i];
      for (int j = 0; j < DEPTH; j++) begin
        if (j != i && elig[j] &&
            is_older(slot_tag[j*TAG_W +: TAG_W], slot_tag[i*TAG_W +: TAG_W]))
          grant[i] = 1'b0;
      end
    end
  end

  always_comb begin
    g_vld = |grant;
    g_op  = 1'b0;
    g_tag = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (grant[i]) begin
        g_op  = slot_op[i];
        g_tag = slot_tag[i*TAG_W +: TAG_W];
      end
    end
  end

  // R4: one winner per half
  p_one_winner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R6: divide granted only with free unit
  p_div_needs_unit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (g_vld && g_op) |-> div_free);
endmodule

// File: rtl/fpis_divtimer.sv
module fpis_divtimer #(
  parameter int unsigned DIV_LAT = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_go,
  output logic div_free
);
  localparam int unsigned CNT_W = (DIV_LAT > 1) ? $clog2(DIV_LAT) : 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (div_go)         cnt <= CNT_W'(DIV_LAT - 1);
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign div_free = (cnt == '0);

  // R6: no launch into a busy unit
  p_no_launch_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !div_free |-> !div_go);

  if (DIV_LAT > 1) begin : g_lat
    // R6: unit busy right after a launch
    p_busy_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
      div_go |=> !div_free);
  end
endmodule

// File: rtl/fpis_issue_sel.sv
module fpis_issue_sel
  import fpis_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned TAG_W   = 8,
  parameter int unsigned DIV_LAT = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 grp_valid,
  output logic                 grp_ready,
  input  logic [3:0]           grp_lane_vld,
  input  logic [3:0]           grp_op,
  input  logic [3:0]           grp_rdy,
  input  logic                 wake_en,
  input  logic [TAG_W-1:0]     wake_tag,
  output logic [1:0]           iss_vld,
  output logic [1:0]           iss_op,
  output logic [2*TAG_W-1:0]   iss_tag
);
  logic [TAG_W-1:0] seq;
  logic [1:0]       room;
  logic             accept;

  assign grp_ready = &room;
  assign accept    = grp_valid && grp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seq <= '0;
    else if (accept) seq <= seq + TAG_W'(LANES);
  end

  for (genvar p = 0; p < PARITIES; p++) begin : g_par
    logic [DEPTH-1:0]       s_vld, s_rdy, s_op, grant;
    logic [DEPTH*TAG_W-1:0] s_tag;
    logic [2*TAG_W-1:0]     a_tag;
    logic                   div_free, g_vld, g_op;
    logic [TAG_W-1:0]       g_tag;

    assign a_tag = {seq + TAG_W'(p + 2), seq + TAG_W'(p)};

    fpis_bank #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_en  (accept),
      .alloc_vld ({grp_lane_vld[p+2], grp_lane_vld[p]}),
      .alloc_op  ({grp_op[p+2], grp_op[p]}),
      .alloc_rdy ({grp_rdy[p+2], grp_rdy[p]}),
      .alloc_tag (a_tag),
      .wake_en   (wake_en),
      .wake_tag  (wake_tag),
      .take      (grant),
      .slot_vld  (s_vld),
      .slot_rdy  (s_rdy),
      .slot_op   (s_op),
      .slot_tag  (s_tag),
      .room      (room[p])
    );

    fpis_pick #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot_vld (s_vld),
      .slot_rdy (s_rdy),
      .slot_op  (s_op),
      .slot_tag (s_tag),
      .div_free (div_free),
      .grant    (grant),
      .g_vld    (g_vld),
      .g_op     (g_op),
      .g_tag    (g_tag)
    );

    fpis_divtimer #(.DIV_LAT(DIV_LAT)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_go   (g_vld && g_op),
      .div_free (div_free)
    );

    assign iss_vld[p]                 = g_vld;
    assign iss_op[p]                  = g_op;
    assign iss_tag[p*TAG_W +: TAG_W]  = g_tag;
  end

  // R3: a held group leaves the sequence alone
  p_hold_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && !grp_ready) |=> $stable(seq));
endmodule

// File: tb/sim_fpis_issue_sel.sv
module sim_fpis_issue_sel;
  localparam int DEPTH = 4;
  localparam int TAG_W = 6;
  localparam int DIV_LAT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic grp_valid = 1'b0;
  logic grp_ready;
  logic [3:0] grp_lane_vld = '0, grp_op = '0, grp_rdy = '0;
  logic wake_en = 1'b0;
  logic [TAG_W-1:0] wake_tag = '0;
  logic [1:0] iss_vld, iss_op;
  logic [2*TAG_W-1:0] iss_tag;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference queue
  bit             m_v[2][DEPTH];
  bit             m_r[2][DEPTH];
  bit             m_o[2][DEPTH];
  logic [TAG_W-1:0] m_t[2][DEPTH];
  int             m_cnt[2];
  logic [TAG_W-1:0] m_seq;

  always #4 clk = ~clk;

  fpis_issue_sel #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DIV_LAT(DIV_LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_ready(grp_ready),
    .grp_lane_vld(grp_lane_vld), .grp_op(grp_op), .grp_rdy(grp_rdy),
    .wake_en(wake_en), .wake_tag(wake_tag),
    .iss_vld(iss_vld), .iss_op(iss_op), .iss_tag(iss_tag));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  function automatic int nfree(input int p);
    int n = 0;
    for (int s = 0; s < DEPTH; s++) if (!m_v[p][s]) n++;
    return n;
  endfunction

  function automatic int pick(input int p);
    int best = -1;
    logic [TAG_W-1:0] d;
    for (int s = 0; s < DEPTH; s++) begin
      if (m_v[p][s] && m_r[p][s] && (!m_o[p][s] || m_cnt[p] == 0)) begin
        d = m_t[p][s] - ((best < 0) ? m_t[p][s] : m_t[p][best]);
        if (best < 0 || d[TAG_W-1]) best = s;
      end
    end
    return best;
  endfunction

  function automatic int live(input int p);
    int n = 0;
    for (int s = 0; s < DEPTH; s++) if (m_v[p][s]) n++;
    return n;
  endfunction

  // oldest tag in the model, span measure for the wrap rule
  function automatic int span();
    int sp = 0;
    logic [TAG_W-1:0] d;
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < DEPTH; s++)
        if (m_v[p][s]) begin
          d = m_seq - m_t[p][s];
          if (int'(d) > sp) sp = int'(d);
        end
    return sp;
  endfunction

  task automatic check_out();
    int w;
    chk({cur_req, " R3 ready"}, int'(grp_ready), int'(nfree(0) >= 2 && nfree(1) >= 2));
    for (int p = 0; p < 2; p++) begin
      w = pick(p);
      chk({cur_req, " R4 iss_vld"}, int'(iss_vld[p]), int'(w >= 0));
      if (w >= 0) begin
        chk({cur_req, " R9 iss_tag"}, int'(iss_tag[p*TAG_W +: TAG_W]), int'(m_t[p][w]));
        chk({cur_req, " R6 iss_op"}, int'(iss_op[p]), int'(m_o[p][w]));
      end
    end
  endtask

  task automatic model_edge();
    int w;
    bit acc;
    int k;
    acc = grp_valid && nfree(0) >= 2 && nfree(1) >= 2;
    for (int p = 0; p < 2; p++) begin
      w = pick(p);
      if (w >= 0) begin
        m_v[p][w] = 0;
        if (m_o[p][w]) m_cnt[p] = DIV_LAT - 1;
        else if (m_cnt[p] > 0) m_cnt[p]--;
      end else if (m_cnt[p] > 0) m_cnt[p]--;
      for (int s = 0; s < DEPTH; s++)
        if (wake_en && m_v[p][s] && m_t[p][s] == wake_tag) m_r[p][s] = 1;
    end
    if (acc) begin
      for (int l = 0; l < 4; l++) begin
        if (grp_lane_vld[l]) begin
          k = 0;
          while (m_v[l%2][k]) k++;
          m_v[l%2][k] = 1;
          m_r[l%2][k] = grp_rdy[l];
          m_o[l%2][k] = grp_op[l];
          m_t[l%2][k] = m_seq + TAG_W'(l);
        end
      end
      m_seq = m_seq + 4;
    end
  endtask

  task automatic step(input bit gv, input logic [3:0] lv, input logic [3:0] op,
                      input logic [3:0] rd, input bit we, input logic [TAG_W-1:0] wt);
    @(negedge clk);
    check_out();
    grp_valid = gv; grp_lane_vld = lv; grp_op = op; grp_rdy = rd;
    wake_en = we; wake_tag = wt;
    @(posedge clk);
    model_edge();
  endtask

  // pick a not-ready live entry: oldest if want_old, else random
  task automatic find_wait(input bit want_old, output bit f, output logic [TAG_W-1:0] t);
    logic [TAG_W-1:0] d;
    int bd = -1;
    f = 0; t = '0;
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < DEPTH; s++)
        if (m_v[p][s] && !m_r[p][s]) begin
          d = m_seq - m_t[p][s];
          if (!f || (want_old && int'(d) > bd) || (!want_old && $urandom_range(1) == 1)) begin
            f = 1; t = m_t[p][s]; bd = int'(d);
          end
        end
  endtask

  task automatic drain();
    bit f;
    logic [TAG_W-1:0] t;
    for (int i = 0; i < 200; i++) begin
      find_wait(1, f, t);
      if (!f && live(0) == 0 && live(1) == 0) break;
      step(0, 4'h0, 4'h0, 4'h0, f, t);
    end
  endtask

  initial begin
    bit f;
    logic [TAG_W-1:0] t;
    for (int p = 0; p < 2; p++) begin
      m_cnt[p] = 0;
      for (int s = 0; s < DEPTH; s++) begin
        m_v[p][s] = 0; m_r[p][s] = 0; m_o[p][s] = 0; m_t[p][s] = '0;
      end
    end
    m_seq = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state held while in reset and right after
    chk("R1 ready in reset", int'(grp_ready), 1);
    chk("R1 no issue in reset", int'(iss_vld), 0);
    rst_n = 1'b1;
    step(0, 4'h0, 4'h0, 4'h0, 0, '0);

    // R2: every lane mask, all ready multiply-accumulate
    cur_req = "R2";
    for (int m = 0; m < 16; m++) begin
      step(1, 4'(m), 4'h0, 4'hF, 0, '0);
      step(0, 4'h0, 4'h0, 4'h0, 0, '0);
      step(0, 4'h0, 4'h0, 4'h0, 0, '0);
    end
    drain();

    // R3: fill with unready work until the queue refuses groups
    cur_req = "R3";
    for (int i = 0; i < 6; i++) step(1, 4'hF, 4'h0, 4'h0, 0, '0);
    drain();

    // R5: unready entries issue only after a wake by tag
    cur_req = "R5";
    step(1, 4'hF, 4'h0, 4'h0, 0, '0);
    for (int i = 0; i < 3; i++) step(0, 4'h0, 4'h0, 4'h0, 0, '0);
    step(0, 4'h0, 4'h0, 4'h0, 1, m_seq - 6'd2);
    step(0, 4'h0, 4'h0, 4'h0, 1, m_seq - 6'd1);
    step(0, 4'h0, 4'h0, 4'h0, 0, '0);
    drain();

    // R6: back-to-back divides in both halves
    cur_req = "R6";
    step(1, 4'hF, 4'hF, 4'hF, 0, '0);
    for (int i = 0; i < 3 * DIV_LAT; i++) step(0, 4'h0, 4'h0, 4'h0, 0, '0);
    drain();

    // R7: older divides blocked, younger multiply-accumulate passes
    cur_req = "R7";
    step(1, 4'hF, 4'hF, 4'hF, 0, '0);
    step(0, 4'h0, 4'h0, 4'h0, 0, '0);
    step(1, 4'hF, 4'h0, 4'h0, 0, '0);
    for (int i = 0; i < 4; i++) begin
      find_wait(1, f, t);
      step(0, 4'h0, 4'h0, 4'h0, f, t);
    end
    drain();

    // R8 R9: long mixed sweep across many tag wraps
    cur_req = "R8 R9";
    for (int i = 0; i < 6000; i++) begin
      find_wait($urandom_range(1) == 1, f, t);
      step((span() < 20) && ($urandom_range(3) != 0), 4'($urandom), 4'($urandom),
           4'($urandom), f && ($urandom_range(3) != 0), t);
    end
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule